// File: doc/BRIEF.md
# Cache-Hit Bus Arbiter

This block decides which master owns the processor bus. Four masters can ask for it: the PCI side, the CPU, a secondary write-back cache and a memory refresh source. Each request is an active-low level. Each grant is an active-high registered output, and at most one grant is high at any time. In normal operation the PCI side keeps its grant, and a refresh request wins over it. A grant that is held changes only when the owner signals the end of its cycle.

When a snooped PCI access hits in a cache, the snoop logic raises `retry_seen` for one cycle. The arbiter then takes the grant away from whichever master holds it. On the following clock it samples the CPU and cache requests. The hitting cache therefore gets the bus to write back its line before the retried PCI master can return. If both the CPU and the cache are requesting, the CPU goes first. The cache is checked again at the end of the CPU cycle and is granted only if it still requests. Because every grant comes from a register, a cache sees its grant before it may issue a transfer start for its burst.

Top module: `cache_hit_arbiter`

## Requirements
- R1: While `rst_n` is low, all four grants are low.
- R2: At most one grant is high in every cycle.
- R3: If `retry_seen` is high at a clock edge while no hit arbitration is running, every grant is low after that edge. This includes the PCI grant.
- R4: At the edge after the R3 edge, a CPU request with no cache request grants the CPU. A cache request with no CPU request grants the cache.
- R5: At that same sample edge, if both the CPU and the cache are requesting, the CPU is granted.
- R6: At the edge where `cycle_end` is high during a hit-driven CPU grant: if the cache was requesting at the sample and is still requesting, the cache is granted. Otherwise the cache is skipped and normal arbitration picks the next owner.
- R7: If neither the CPU nor the cache is requesting at the sample edge, normal arbitration applies at once.
- R8: Normal arbitration uses the order refresh, then PCI, then CPU, then cache. It runs on every clock while no grant is held. A held grant stays unchanged until an edge where `cycle_end` is high.
- R9: While hit arbitration is running (the sample cycle and any hit-driven grant), `retry_seen` has no effect. `cycle_end` has no effect during the sample cycle.
- R10: At the edge where `cycle_end` is high during a hit-driven cache grant, normal arbitration picks the next owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pci_req_n | input | 1 | PCI side bus request, active low |
| cpu_req_n | input | 1 | CPU bus request, active low |
| cache_req_n | input | 1 | Secondary cache bus request, active low |
| refresh_req_n | input | 1 | Refresh source bus request, active low |
| retry_seen | input | 1 | One-cycle pulse: a snoop retry was observed |
| cycle_end | input | 1 | The current owner's bus cycle ends this clock |
| pci_gnt | output | 1 | Grant to the PCI side |
| cpu_gnt | output | 1 | Grant to the CPU |
| cache_gnt | output | 1 | Grant to the secondary cache |
| refresh_gnt | output | 1 | Grant to the refresh source |

## Verification
The hit path is swept over all eight combinations of refresh, CPU and cache requests present at the sample edge, with PCI always asking. This separates the CPU-first case, the cache-only case and the fall-back to normal order. Each case where the CPU wins is run twice: once with the cache still asking at CPU cycle end and once with it withdrawn. This shows whether the re-check uses the live request. Stray `retry_seen` and `cycle_end` pulses are injected inside the hit sequence to show they are ignored. A second sweep covers all sixteen request patterns in normal mode, then checks that a held grant survives a new refresh request until the owner ends its cycle.

// File: rtl/cache_hit_arbiter_pkg.sv
package cache_hit_arbiter_pkg;
    localparam int NUM_MASTERS = 4;
    localparam int IDX_PCI     = 0;
    localparam int IDX_CPU     = 1;
    localparam int IDX_CACHE   = 2;
    localparam int IDX_REF     = 3;

    typedef enum logic [1:0] {
        ST_NORMAL    = 2'd0,
        ST_SAMPLE    = 2'd1,
        ST_HIT_CPU   = 2'd2,
        ST_HIT_CACHE = 2'd3
    } arb_state_e;

    typedef struct packed {
        arb_state_e              st;
        logic                    cache_after;
        logic [NUM_MASTERS-1:0]  gnt;
    } arb_regs_s;
endpackage

// File: rtl/fixed_prio_pick.sv
module fixed_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    logic found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/req_level_in.sv
module req_level_in #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_n,
    output logic [N-1:0] act
);
    for (genvar g = 0; g < N; g++) begin : g_inv
        assign act[g] = ~req_n[g];
    end
endmodule

// File: rtl/cache_hit_arbiter.sv
module cache_hit_arbiter
    import cache_hit_arbiter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pci_req_n,
    input  logic cpu_req_n,
    input  logic cache_req_n,
    input  logic refresh_req_n,
    input  logic retry_seen,
    input  logic cycle_end,
    output logic pci_gnt,
    output logic cpu_gnt,
    output logic cache_gnt,
    output logic refresh_gnt
);
    localparam int NM = NUM_MASTERS;

    logic [NM-1:0] raw_n;
    logic [NM-1:0] act;
    logic [NM-1:0] norm_req, norm_pick, norm_gnt;
    logic [NM-1:0] hit_req, hit_pick, hit_gnt;
    logic [NM-1:0] cache_only;
    arb_regs_s     r_d, r_q;

    assign raw_n[IDX_PCI]   = pci_req_n;
    assign raw_n[IDX_CPU]   = cpu_req_n;
    assign raw_n[IDX_CACHE] = cache_req_n;
    assign raw_n[IDX_REF]   = refresh_req_n;

    req_level_in #(.N(NM)) u_lvl (
        .req_n (raw_n),
        .act   (act)
    );

    // normal order: refresh, PCI, CPU, cache (bit 0 is highest)
    assign norm_req = {act[IDX_CACHE], act[IDX_CPU], act[IDX_PCI], act[IDX_REF]};

    fixed_prio_pick #(.N(NM)) u_norm (
        .req  (norm_req),
        .pick (norm_pick)
    );

    always_comb begin
        norm_gnt            = '0;
        norm_gnt[IDX_REF]   = norm_pick[0];
        norm_gnt[IDX_PCI]   = norm_pick[1];
        norm_gnt[IDX_CPU]   = norm_pick[2];
        norm_gnt[IDX_CACHE] = norm_pick[3];
    end

    // hit order: CPU, cache, then refresh, PCI
    assign hit_req = {act[IDX_PCI], act[IDX_REF], act[IDX_CACHE], act[IDX_CPU]};

    fixed_prio_pick #(.N(NM)) u_hit (
        .req  (hit_req),
        .pick (hit_pick)
    );

    always_comb begin
        hit_gnt            = '0;
        hit_gnt[IDX_CPU]   = hit_pick[0];
        hit_gnt[IDX_CACHE] = hit_pick[1];
        hit_gnt[IDX_REF]   = hit_pick[2];
        hit_gnt[IDX_PCI]   = hit_pick[3];
        cache_only            = '0;
        cache_only[IDX_CACHE] = 1'b1;
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_NORMAL: begin
                if (retry_seen) begin
                    r_d.gnt = '0;
                    r_d.st  = ST_SAMPLE;
                end else if ((r_q.gnt == '0) || cycle_end) begin
                    r_d.gnt = norm_gnt;
                end
            end
            ST_SAMPLE: begin
                r_d.gnt         = hit_gnt;
                r_d.cache_after = 1'b0;
                if (hit_gnt[IDX_CPU]) begin
                    r_d.st          = ST_HIT_CPU;
                    r_d.cache_after = act[IDX_CACHE];
                end else if (hit_gnt[IDX_CACHE]) begin
                    r_d.st = ST_HIT_CACHE;
                end else begin
                    r_d.st = ST_NORMAL;
                end
            end
            ST_HIT_CPU: begin
                if (cycle_end) begin
                    r_d.cache_after = 1'b0;
                    if (r_q.cache_after && act[IDX_CACHE]) begin
                        r_d.gnt = cache_only;
                        r_d.st  = ST_HIT_CACHE;
                    end else begin
                        r_d.gnt = norm_gnt;
                        r_d.st  = ST_NORMAL;
                    end
                end
            end
            ST_HIT_CACHE: begin
                if (cycle_end) begin
                    r_d.gnt = norm_gnt;
                    r_d.st  = ST_NORMAL;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st          <= ST_NORMAL;
            r_q.cache_after <= 1'b0;
            r_q.gnt         <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pci_gnt     = r_q.gnt[IDX_PCI];
    assign cpu_gnt     = r_q.gnt[IDX_CPU];
    assign cache_gnt   = r_q.gnt[IDX_CACHE];
    assign refresh_gnt = r_q.gnt[IDX_REF];
endmodule

// File: rtl/cache_hit_arbiter_chk.sv
module cache_hit_arbiter_chk
    import cache_hit_arbiter_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req_n,
    input logic       cache_req_n,
    input logic       retry_seen,
    input logic       cycle_end,
    input logic       pci_gnt,
    input logic       cpu_gnt,
    input logic       cache_gnt,
    input logic       refresh_gnt,
    input arb_state_e st,
    input logic       cache_after
);
    logic [3:0] g;
    assign g = {refresh_gnt, cache_gnt, cpu_gnt, pci_gnt};

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(g));

    assert_retry_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NORMAL && retry_seen) |=> (g == 4'b0000));

    assert_cache_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SAMPLE && cpu_req_n && !cache_req_n) |=> (g == 4'b0100));

    assert_cpu_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SAMPLE && !cpu_req_n) |=> (g == 4'b0010));

    assert_cache_recheck_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIT_CPU && cache_after && cycle_end && !cache_req_n) |=> (g == 4'b0100));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NORMAL && g != 4'b0000 && !cycle_end && !retry_seen) |=> $stable(g));

    assert_hit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_HIT_CPU || st == ST_HIT_CACHE) && !cycle_end) |=> $stable(g));
endmodule

bind cache_hit_arbiter cache_hit_arbiter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req_n   (cpu_req_n),
    .cache_req_n (cache_req_n),
    .retry_seen  (retry_seen),
    .cycle_end   (cycle_end),
    .pci_gnt     (pci_gnt),
    .cpu_gnt     (cpu_gnt),
    .cache_gnt   (cache_gnt),
    .refresh_gnt (refresh_gnt),
    .st          (r_q.st),
    .cache_after (r_q.cache_after)
);

// File: tb/tb_cache_hit_arbiter.sv
module tb_cache_hit_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pci_req_n = 1'b1, cpu_req_n = 1'b1, cache_req_n = 1'b1, refresh_req_n = 1'b1;
    logic retry_seen = 1'b0, cycle_end = 1'b0;
    logic pci_gnt, cpu_gnt, cache_gnt, refresh_gnt;

    int checks = 0;
    int fails  = 0;

    localparam logic [3:0] G_NONE = 4'b0000, G_PCI = 4'b0001, G_CPU = 4'b0010,
                           G_CACHE = 4'b0100, G_REF = 4'b1000;

    always #5 clk = ~clk;

    cache_hit_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .pci_req_n(pci_req_n), .cpu_req_n(cpu_req_n),
        .cache_req_n(cache_req_n), .refresh_req_n(refresh_req_n),
        .retry_seen(retry_seen), .cycle_end(cycle_end),
        .pci_gnt(pci_gnt), .cpu_gnt(cpu_gnt),
        .cache_gnt(cache_gnt), .refresh_gnt(refresh_gnt)
    );

    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {refresh_gnt, cache_gnt, cpu_gnt, pci_gnt};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s grants actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] norm_exp(input bit r, input bit p, input bit c, input bit k);
        if (r) return G_REF;
        if (p) return G_PCI;
        if (c) return G_CPU;
        if (k) return G_CACHE;
        return G_NONE;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pci_req_n = 1'b1; cpu_req_n = 1'b1; cache_req_n = 1'b1; refresh_req_n = 1'b1;
        retry_seen = 1'b0; cycle_end = 1'b0;
        @(negedge clk);
        chk("R1", G_NONE);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_hit(input bit r, input bit c, input bit k, input bit keep);
        logic [3:0] e1, e2;
        do_reset();
        pci_req_n = 1'b0;
        @(negedge clk);
        chk("R8", G_PCI);
        refresh_req_n = !r; cpu_req_n = !c; cache_req_n = !k;
        retry_seen = 1'b1;
        @(negedge clk);
        chk("R3", G_NONE);
        cycle_end = 1'b1;   // R9: retry and cycle_end in sample cycle ignored
        @(negedge clk);
        retry_seen = 1'b0; cycle_end = 1'b0;
        e1 = c ? G_CPU : (k ? G_CACHE : norm_exp(r, 1'b1, 1'b0, 1'b0));
        if (c)      chk("R5", e1);
        else if (k) chk("R4", e1);
        else        chk("R7", e1);
        if (e1 == G_CPU) begin
            retry_seen = 1'b1;
            @(negedge clk);
            retry_seen = 1'b0;
            chk("R9", G_CPU);
            cycle_end = 1'b1; cpu_req_n = 1'b1; cache_req_n = !(k && keep);
            @(negedge clk);
            cycle_end = 1'b0;
            e2 = (k && keep) ? G_CACHE : norm_exp(r, 1'b1, 1'b0, 1'b0);
            chk("R6", e2);
            if (e2 == G_CACHE) begin
                cycle_end = 1'b1; cache_req_n = 1'b1;
                @(negedge clk);
                cycle_end = 1'b0;
                chk("R10", norm_exp(r, 1'b1, 1'b0, 1'b0));
            end
        end else if (e1 == G_CACHE) begin
            retry_seen = 1'b1;
            @(negedge clk);
            retry_seen = 1'b0;
            chk("R9", G_CACHE);
            cycle_end = 1'b1; cache_req_n = 1'b1;
            @(negedge clk);
            cycle_end = 1'b0;
            chk("R10", norm_exp(r, 1'b1, 1'b0, 1'b0));
        end
    endtask

    task automatic run_norm(input int v);
        logic [3:0] e;
        do_reset();
        refresh_req_n = !v[3]; pci_req_n = !v[2]; cpu_req_n = !v[1]; cache_req_n = !v[0];
        e = norm_exp(v[3], v[2], v[1], v[0]);
        @(negedge clk);
        chk("R8", e);
        if (e != G_NONE) begin
            refresh_req_n = 1'b0;
            @(negedge clk);
            chk("R8", e);
            cycle_end = 1'b1;
            @(negedge clk);
            cycle_end = 1'b0;
            chk("R8", G_REF);
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int v = 0; v < 8; v++) begin
            for (int kp = 0; kp < 2; kp++) begin
                run_hit(v[2], v[1], v[0], kp[0]);
            end
        end
        for (int v = 0; v < 16; v++) begin
            run_norm(v);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule